// File: doc/BRIEF.md
# Fifteen-Level Prioritised Interrupt Controller

This block collects interrupt events from the on-chip peripherals of a small processor subsystem and presents one request level to the processor core. Five internal event lines are wired to fixed levels: two serial channels, a receive-overflow error line, a general-purpose timer and a real-time clock. Each event pulse sets a sticky pending bit for its level. There are no external interrupt pins, so the block has no edge or level shaping stage. Every request is already a one-cycle internal pulse.

Software reaches the controller through a word-wide register port. It can read the pending bits, choose which levels are enabled, and drop pending bits by writing ones to a clear location. A read-write force register can raise any of the fifteen levels without a peripheral, which lets software test every interrupt path. The core sees the highest-numbered enabled request on a 4-bit level output. It acknowledges a level by pulsing an acknowledge line with that level number, and this retires both the latched and the forced request for the level.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the pending, enable and force registers all read as zero, and `irq_level` is 0.
- R2: A one-cycle pulse on an event input sets a sticky pending bit on the next clock edge. The bit level is 4 for `uart_a_evt`, 5 for `uart_b_evt`, 3 for `uart_rx_ovf`, 12 for `gpt_tick` and 13 for `rtc_tick`. Bit n of a register word stands for level n.
- R3: A write to offset 0x50 clears every pending bit whose data bit is 1 and leaves bits written as 0 unchanged. A read at 0x50 returns 0.
- R4: The enable register at offset 0x4C reads back what was written. Bit n = 1 enables level n. A pending level whose enable bit is 0 stays pending but is never presented on `irq_level`.
- R5: The force register at offset 0x54 reads back what was written. A set force bit acts as a request for its level. The pending view at offset 0x48 returns the OR of the latched and forced bits. Writes to 0x50 do not alter the force register.
- R6: `irq_level` is the highest level n for which (latched or forced) and enabled are both true, or 0 when no level qualifies. It follows the registers combinationally.
- R7: A clock edge with `irq_ack` high and `irq_ack_level` = n (1..15) clears the latched bit and the force bit of level n and leaves every other level unchanged. An acknowledge of level 0 does nothing.
- R8: An event arriving in the same cycle as a clear or an acknowledge of its level leaves the bit set. The acknowledge clears the force bit in that cycle even when a force write lands at the same edge.
- R9: Bit 0 and bits 31:16 of every register read as 0, and writes to them are ignored. Offset 0x48 is read-only. Any other offset reads 0 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| uart_a_evt | input | 1 | Serial channel A character event |
| uart_b_evt | input | 1 | Serial channel B character event |
| uart_rx_ovf | input | 1 | Serial receive overflow event |
| gpt_tick | input | 1 | General-purpose timer underflow event |
| rtc_tick | input | 1 | Real-time clock underflow event |
| irq_level | output | 4 | Highest enabled requesting level, 0 if none |
| irq_ack | input | 1 | Processor acknowledge strobe |
| irq_ack_level | input | 4 | Level being acknowledged |

## Verification
The directed part starts with single events on each mapped level, first with every level disabled and then with all enabled. It then adds nested requests so that the priority choice has to pick the higher of two live levels. Some patterns put an event in the same cycle as a clear or an acknowledge of its own level, which shows that new events take precedence over clears. Others force a level that also has a latched bit, which shows that the latched and forced state are kept apart. The random phase mixes sparse and dense force and enable words with random events, clears and acknowledges of both the current level and arbitrary levels. This shows that an acknowledge touches only its own level. Reads of unmapped offsets and writes of reserved bits confirm that they are ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // byte offsets of the register locations
  localparam logic [7:0] OFS_PEND  = 8'h48;
  localparam logic [7:0] OFS_MASK  = 8'h4C;
  localparam logic [7:0] OFS_CLEAR = 8'h50;
  localparam logic [7:0] OFS_FORCE = 8'h54;

  // decoded register access for one cycle
  typedef struct packed {
    logic wr_mask;
    logic wr_clear;
    logic wr_force;
    logic rd_pend;
    logic rd_mask;
    logic rd_force;
  } csr_hit_t;

  // index of the highest set bit above bit 0, or 0 when none
  function automatic int unsigned top_set_index(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int unsigned k = 1; k < 32; k++) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

  // access decode from strobe, direction and offset
  function automatic csr_hit_t decode_access(input logic sel, input logic wr,
                                             input logic [7:0] ofs);
    csr_hit_t h;
    h.wr_mask  = sel &  wr & (ofs == OFS_MASK);
    h.wr_clear = sel &  wr & (ofs == OFS_CLEAR);
    h.wr_force = sel &  wr & (ofs == OFS_FORCE);
    h.rd_pend  = sel & ~wr & (ofs == OFS_PEND);
    h.rd_mask  = sel & ~wr & (ofs == OFS_MASK);
    h.rd_force = sel & ~wr & (ofs == OFS_FORCE);
    return h;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [N:1] set_vec,
  input  logic [N:1] clr_vec,
  input  logic [N:1] ack_vec,
  output logic [N:1] pend
);

  for (genvar i = 1; i <= N; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= set_vec[i] | (pend[i] & ~clr_vec[i] & ~ack_vec[i]);
    end
  end

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));             // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));  // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & ~set_vec)) |=> ((pend & $past(ack_vec & ~set_vec)) == '0));  // R7

  AST_ACK_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));                                                       // R7

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N  = 15,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N:1]    req,
  output logic [N:1]    grant,
  output logic [LW-1:0] level
);
  import irq_pkg::*;

  logic [N:1] above;

  for (genvar i = 1; i <= N; i++) begin : g_chain
    if (i == N) begin : g_top
      assign above[i] = 1'b0;
    end else begin : g_mid
      assign above[i] = above[i+1] | req[i+1];
    end
    assign grant[i] = req[i] & ~above[i];
  end

  assign level = LW'(top_set_index(32'({req, 1'b0})));

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));                                                         // R6

  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> grant[level]);                                          // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (level == '0));                                         // R6

endmodule

// File: rtl/irq_csr.sv
module irq_csr #(
  parameter int unsigned N  = 15,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N:1]    pend_view,
  input  logic [N:1]    ack_vec,
  output logic [N:1]    mask,
  output logic [N:1]    frc,
  output logic [N:1]    clr_vec
);
  import irq_pkg::*;

  localparam int unsigned PAD_W = DW - N - 1;

  csr_hit_t   hit;
  logic [N:1] wbits;
  logic       unused_wdata;

  assign hit          = decode_access(bus_sel, bus_wr, 8'(bus_addr));
  assign wbits        = bus_wdata[N:1];
  assign unused_wdata = ^{bus_wdata[DW-1:N+1], bus_wdata[0]};
  assign clr_vec      = hit.wr_clear ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      frc  <= '0;
    end else begin
      if (hit.wr_mask) mask <= wbits;
      frc <= (hit.wr_force ? wbits : frc) & ~ack_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit.rd_pend)  bus_rdata = {{PAD_W{1'b0}}, pend_view, 1'b0};
    if (hit.rd_mask)  bus_rdata = {{PAD_W{1'b0}}, mask, 1'b0};
    if (hit.rd_force) bus_rdata = {{PAD_W{1'b0}}, frc, 1'b0};
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit.wr_mask |=> $stable(mask));                                          // R4

  AST_FORCE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec) |=> ((frc & $past(ack_vec)) == '0));                           // R8

  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit.wr_force && ack_vec == '0) |=> $stable(frc));                       // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[0] == 1'b0) && (bus_rdata[DW-1:N+1] == '0));                   // R9

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned NUM_LEVELS   = 15,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned LVL_W        = $clog2(NUM_LEVELS + 1),
  parameter int unsigned LVL_UART_A   = 4,
  parameter int unsigned LVL_UART_B   = 5,
  parameter int unsigned LVL_UART_ERR = 3,
  parameter int unsigned LVL_GPT      = 12,
  parameter int unsigned LVL_RTC      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uart_a_evt,
  input  logic              uart_b_evt,
  input  logic              uart_rx_ovf,
  input  logic              gpt_tick,
  input  logic              rtc_tick,
  output logic [LVL_W-1:0]  irq_level,
  input  logic              irq_ack,
  input  logic [LVL_W-1:0]  irq_ack_level
);

  localparam int unsigned N = NUM_LEVELS;

  logic [N:1] set_vec;
  logic [N:1] clr_vec;
  logic [N:1] ack_vec;
  logic [N:1] pend;
  logic [N:1] frc;
  logic [N:1] mask;
  logic [N:1] live_req;
  logic [N:1] grant;

  // fixed routing of the internal event lines
  always_comb begin
    set_vec = '0;
    set_vec[LVL_UART_A]   = set_vec[LVL_UART_A]   | uart_a_evt;
    set_vec[LVL_UART_B]   = set_vec[LVL_UART_B]   | uart_b_evt;
    set_vec[LVL_UART_ERR] = set_vec[LVL_UART_ERR] | uart_rx_ovf;
    set_vec[LVL_GPT]      = set_vec[LVL_GPT]      | gpt_tick;
    set_vec[LVL_RTC]      = set_vec[LVL_RTC]      | rtc_tick;
  end

  // acknowledge level to a one-hot retire vector
  always_comb begin
    ack_vec = '0;
    for (int unsigned i = 1; i <= N; i++) begin
      if (irq_ack && (irq_ack_level == LVL_W'(i))) ack_vec[i] = 1'b1;
    end
  end

  assign live_req = (pend | frc) & mask;

  irq_pend_bank #(.N(N)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .ack_vec (ack_vec),
    .pend    (pend)
  );

  irq_csr #(.N(N), .AW(ADDR_W), .DW(DATA_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_view (pend | frc),
    .ack_vec   (ack_vec),
    .mask      (mask),
    .frc       (frc),
    .clr_vec   (clr_vec)
  );

  irq_prio_sel #(.N(N), .LW(LVL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (live_req),
    .grant (grant),
    .level (irq_level)
  );

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> mask[irq_level]);                                   // R4

  AST_LEVEL_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (pend[irq_level] | frc[irq_level]));                // R6

  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    uart_a_evt |=> pend[LVL_UART_A]);                                         // R2

  AST_ACK_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_ack_level == '0) |-> (ack_vec == '0));                    // R7

endmodule

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        uart_a_evt = 1'b0, uart_b_evt = 1'b0, uart_rx_ovf = 1'b0;
  logic        gpt_tick = 1'b0, rtc_tick = 1'b0;
  logic [3:0]  irq_level;
  logic        irq_ack = 1'b0;
  logic [3:0]  irq_ack_level = '0;

  always #2.5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_a_evt(uart_a_evt), .uart_b_evt(uart_b_evt), .uart_rx_ovf(uart_rx_ovf),
    .gpt_tick(gpt_tick), .rtc_tick(rtc_tick), .irq_level(irq_level),
    .irq_ack(irq_ack), .irq_ack_level(irq_ack_level)
  );

  // staged stimulus, copied to the pins at the falling edge
  logic        s_sel, s_wr, s_ack;
  logic [7:0]  s_addr;
  logic [31:0] s_wdata;
  logic [4:0]  s_src;   // {rtc, gpt, ovf, uart_b, uart_a}
  logic [3:0]  s_lvl;

  // reference state
  logic [15:0] m_pend, m_mask, m_force;
  int nvec = 0, nfail = 0;
  bit done = 0;

  function automatic logic [15:0] src_bits(input logic [4:0] s);
    logic [15:0] b;
    b = '0;
    if (s[0]) b[4]  = 1'b1;
    if (s[1]) b[5]  = 1'b1;
    if (s[2]) b[3]  = 1'b1;
    if (s[3]) b[12] = 1'b1;
    if (s[4]) b[13] = 1'b1;
    return b;
  endfunction

  function automatic logic [3:0] want_level(input logic [15:0] v);
    logic [3:0] r;
    r = 0;
    for (int k = 1; k < 16; k++) if (v[k]) r = 4'(k);
    return r;
  endfunction

  function automatic logic [31:0] want_read(input logic [7:0] a);
    case (a)
      8'h48:   return {16'h0, (m_pend | m_force) & 16'hFFFE};
      8'h4C:   return {16'h0, m_mask};
      8'h54:   return {16'h0, m_force};
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle_stage();
    s_sel = 0; s_wr = 0; s_addr = 0; s_wdata = 0; s_src = 0; s_ack = 0; s_lvl = 0;
  endtask

  task automatic tick(input string tag);
    logic [15:0] setv, clrv, ackv;
    logic [3:0]  lv;
    logic [31:0] rd;
    @(negedge clk);
    bus_sel = s_sel; bus_wr = s_wr; bus_addr = s_addr; bus_wdata = s_wdata;
    {rtc_tick, gpt_tick, uart_rx_ovf, uart_b_evt, uart_a_evt} = s_src;
    irq_ack = s_ack; irq_ack_level = s_lvl;
    #1;
    lv = want_level((m_pend | m_force) & m_mask);
    nvec++;
    if (irq_level !== lv) begin
      nfail++;
      $display("FAIL %s irq_level actual=%0d expected=%0d", tag, irq_level, lv);
    end
    if (s_sel && !s_wr) begin
      rd = want_read(s_addr);
      nvec++;
      if (bus_rdata !== rd) begin
        nfail++;
        $display("FAIL %s read @%h actual=%h expected=%h", tag, s_addr, bus_rdata, rd);
      end
    end
    @(posedge clk);
    setv = src_bits(s_src);
    ackv = (s_ack && s_lvl != 0) ? (16'h1 << s_lvl) : 16'h0;
    clrv = (s_sel && s_wr && s_addr == 8'h4C + 8'h04) ? s_wdata[15:0] : 16'h0;
    m_pend = (((m_pend & ~clrv & ~ackv) | setv) & 16'hFFFE);
    if (s_sel && s_wr && s_addr == 8'h4C) m_mask = s_wdata[15:0] & 16'hFFFE;
    m_force = ((s_sel && s_wr && s_addr == 8'h54) ? s_wdata[15:0] : m_force) & ~ackv & 16'hFFFE;
    idle_stage();
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    s_sel = 1; s_wr = 1; s_addr = a; s_wdata = d; tick(tag);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    s_sel = 1; s_wr = 0; s_addr = a; tick(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL all requirements: watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_pend = 0; m_mask = 0; m_force = 0;
    idle_stage();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd(8'h48, "R1 pend"); do_rd(8'h4C, "R1 mask"); do_rd(8'h54, "R1 force");

    // R2 each source sets its level; R4 disabled level stays hidden
    s_src = 5'b00001; tick("R2 uart_a");
    do_rd(8'h48, "R2 R4 pend while disabled");
    s_src = 5'b11110; tick("R2 others");
    do_rd(8'h48, "R2 all sources");
    do_wr(8'h4C, 32'hFFFF_FFFF, "R9 mask upper bits");
    do_rd(8'h4C, "R4 R9 mask readback");
    tick("R6 highest is 13");

    // R3 clear ones only, zeros leave bits
    do_wr(8'h50, 32'h0000_2001, "R3 clear 13");
    do_rd(8'h48, "R3 after clear");
    do_wr(8'h50, 32'h0, "R3 clear zero");
    do_rd(8'h50, "R3 clear reads 0");

    // R5 force
    do_wr(8'h54, 32'h0000_8000, "R5 force 15");
    do_rd(8'h54, "R5 force readback");
    do_wr(8'h50, 32'h0000_8000, "R5 clear leaves force");
    do_rd(8'h48, "R5 pend view");

    // R7 acknowledge
    s_ack = 1; s_lvl = 15; tick("R7 ack 15");
    do_rd(8'h54, "R7 force dropped");
    s_ack = 1; s_lvl = 0; tick("R7 ack 0 no effect");
    s_ack = 1; s_lvl = 12; tick("R7 ack 12");
    do_rd(8'h48, "R7 others kept");

    // R8 event beats clear and ack in same cycle
    s_sel = 1; s_wr = 1; s_addr = 8'h50; s_wdata = 32'h10; s_src = 5'b00001; tick("R8 ev+clear");
    do_rd(8'h48, "R8 kept after clear");
    s_ack = 1; s_lvl = 5; s_src = 5'b00010; tick("R8 ev+ack");
    do_rd(8'h48, "R8 kept after ack");
    s_sel = 1; s_wr = 1; s_addr = 8'h54; s_wdata = 32'h20; s_ack = 1; s_lvl = 5; tick("R8 force+ack");
    do_rd(8'h54, "R8 ack beats force write");

    // R4 disabling upper level drops to lower
    do_wr(8'h4C, 32'h0000_0010, "R4 only 4 enabled");
    tick("R4 level 4");

    // R9 read-only pending, unmapped offsets
    do_wr(8'h48, 32'hFFFF_FFFF, "R9 pend write ignored");
    do_rd(8'h48, "R9 pend unchanged");
    do_wr(8'h58, 32'hFFFF_FFFF, "R9 unmapped write");
    do_rd(8'h58, "R9 unmapped read");
    do_rd(8'h4C, "R9 mask unaffected");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0: begin s_sel = 1; s_wr = 1; s_addr = 8'h4C; s_wdata = $urandom; end
        1: begin s_sel = 1; s_wr = 1; s_addr = 8'h54; s_wdata = $urandom & $urandom & $urandom; end
        2: begin s_sel = 1; s_wr = 1; s_addr = 8'h50; s_wdata = $urandom; end
        3, 4, 5: begin
          logic [7:0] ofs [5];
          ofs[0] = 8'h48; ofs[1] = 8'h4C; ofs[2] = 8'h50; ofs[3] = 8'h54; ofs[4] = 8'($urandom);
          s_sel = 1; s_wr = 0; s_addr = ofs[$urandom % 5];
        end
        default: ;
      endcase
      for (int b = 0; b < 5; b++) s_src[b] = ($urandom % 6) == 0;
      if (($urandom % 4) == 0) begin
        s_ack = 1;
        s_lvl = (($urandom % 3) == 0) ? 4'($urandom) : want_level((m_pend | m_force) & m_mask);
      end
      tick("R6 R7 R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule